// File: doc/BRIEF.md
# Multi-Context Instruction Hierarchy Stack

This block tracks, for several interleaved programs, the chain of instruction addresses that are still being interpreted. Each program owns its own context, a small stack. The top entry is the address of the instruction being interpreted right now. Each entry below it is the address of the calling instruction in the next outer routine, and so on up to the outermost routine. A set of active bits records which contexts hold a program that has started and not yet finished. The control unit picks one of those contexts as the selected one.

Each cycle, the control unit issues one operation. A call pushes a routine's entry address. A return pops the top entry and steps the caller's entry by one, so the caller resumes at its next instruction. An advance steps the top address by one. The other operations create or retire a context and switch the selected context. The block returns the selected context's current address, its depth and validity, the active set, sticky overflow and underflow flags for each context, and a one-cycle completion pulse for each context.

Top module: `ctx_hier_stack`

## Requirements
- R1: After reset every context is empty and inactive, the selected context is 0, `cur_valid`, `cur_addr`, `cur_depth`, `active_mask`, the flag vectors and `done_pulse` are all zero.
- R2: `op`=4 (create) on a context whose active bit is clear makes it active with depth 1, with top entry `op_addr`, and clears its overflow and underflow flags. On an already active context, create changes nothing.
- R3: `op`=1 (call) on an active selected context below the depth limit pushes `op_addr`. From the next edge, `cur_addr` equals `op_addr` and `cur_depth` is one larger. The caller's entry is left unchanged.
- R4: `op`=2 (return) on a selected context of depth 2 or more removes the top entry. The new top entry becomes the caller's address plus one, modulo 2^AW.
- R5: A call on a full selected context (depth DEPTH=16) is refused, so the depth and entries are unchanged. The context's bit in `ovf_flags` is set and stays set until that context is created again.
- R6: A return on an empty selected context is refused and sets that context's bit in `unf_flags`. The bit stays set until that context is created again.
- R7: `op`=6 (switch) selects context `op_ctx`. From the next edge, `cur_ctx`, `cur_addr`, `cur_depth` and `cur_valid` describe that context. The entries of the other contexts are kept untouched.
- R8: A return on a selected context of depth 1 empties it and clears its active bit. Its bit in `done_pulse` is high for exactly the following cycle.
- R9: `op`=5 (retire) on context `op_ctx` empties it and clears its active bit without a `done_pulse`. Its flags are kept.
- R10: `op`=3 (advance) adds one, modulo 2^AW, to the selected context's top entry. On an empty context it has no effect.
- R11: A call on an inactive selected context, and `op` codes 0 and 7, change no state and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation code (0 nop, 1 call, 2 return, 3 advance, 4 create, 5 retire, 6 switch, 7 nop) |
| op_addr | input | AW (16) | Entry address for call and create |
| op_ctx | input | CW (2) | Target context for create, retire and switch |
| cur_addr | output | AW (16) | Top entry of the selected context, zero when empty |
| cur_valid | output | 1 | Selected context is non-empty |
| cur_depth | output | DW (5) | Number of entries in the selected context |
| cur_ctx | output | CW (2) | Selected context index |
| active_mask | output | NUM_CTX (4) | One active bit per context |
| ovf_flags | output | NUM_CTX (4) | Sticky overflow flag per context |
| unf_flags | output | NUM_CTX (4) | Sticky underflow flag per context |
| done_pulse | output | NUM_CTX (4) | One-cycle pulse when a context finishes by return |

## Verification
The bench fills a context to 16 entries and then calls once more. A design with an off-by-one limit would either refuse the sixteenth push or overwrite beyond the top. It returns through a chain of calls and checks that each resumed caller shows its own address plus one. A design that kept the next address, or that forgot the step, would show the raw caller address. It advances an address of all ones to check the wraparound. It returns from the last entry and from an empty context, where a design that mixed the two would miss the done pulse or wrongly flag underflow. It also interleaves switches, creates and retires across contexts, so a design that shared storage or leaked a command into an unselected context shows the wrong address after a switch.

// File: rtl/ctx_hier_pkg.sv
package ctx_hier_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_CALL = 3'd1,
        OP_RET  = 3'd2,
        OP_ADV  = 3'd3,
        OP_NEW  = 3'd4,
        OP_KILL = 3'd5,
        OP_SEL  = 3'd6
    } hier_op_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic adv;
        logic create;
        logic retire;
    } lane_cmd_t;

endpackage

// File: rtl/ctx_op_decode.sv
module ctx_op_decode
    import ctx_hier_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int CW      = 2
) (
    input  logic [2:0]                    op,
    input  logic [CW-1:0]                 op_ctx,
    input  logic [CW-1:0]                 sel_q,
    output lane_cmd_t [NUM_CTX-1:0]       cmd,
    output logic [CW-1:0]                 sel_d
);

    // Stack operations act on the selected context; lifecycle operations
    // act on the context named by op_ctx.
    always_comb begin
        cmd   = '0;
        sel_d = sel_q;
        case (op)
            OP_CALL: cmd[sel_q].push    = 1'b1;
            OP_RET:  cmd[sel_q].pop     = 1'b1;
            OP_ADV:  cmd[sel_q].adv     = 1'b1;
            OP_NEW:  cmd[op_ctx].create = 1'b1;
            OP_KILL: cmd[op_ctx].retire = 1'b1;
            OP_SEL:  sel_d              = op_ctx;
            default: ;
        endcase
    end

endmodule

// File: rtl/ctx_lane.sv
module ctx_lane
    import ctx_hier_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 16,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lane_cmd_t     cmd,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] depth_q,
    output logic          active_q,
    output logic          ovf_q,
    output logic          unf_q,
    output logic          done_q,
    output logic [AW-1:0] top_next,
    output logic [DW-1:0] depth_next
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] ent;
        logic [DW-1:0]            depth;
        logic                     act;
        logic                     ovf;
        logic                     unf;
        logic                     done;
    } lane_st_t;

    lane_st_t      s_d, s_q;
    logic [IW-1:0] top_idx, sec_idx, nxt_idx;
    logic [AW-1:0] top_q, sec_q;

    always_comb begin
        top_idx = IW'(s_q.depth - DW'(1));
        sec_idx = IW'(s_q.depth - DW'(2));
        top_q   = s_q.ent[top_idx];
        sec_q   = s_q.ent[sec_idx];

        s_d      = s_q;
        s_d.done = 1'b0;

        if (cmd.create) begin
            if (!s_q.act) begin
                s_d.ent[0] = addr;
                s_d.depth  = DW'(1);
                s_d.act    = 1'b1;
                s_d.ovf    = 1'b0;
                s_d.unf    = 1'b0;
            end
        end else if (cmd.retire) begin
            s_d.act   = 1'b0;
            s_d.depth = '0;
        end else if (cmd.push) begin
            if (s_q.act) begin
                if (s_q.depth == DW'(DEPTH)) begin
                    s_d.ovf = 1'b1;
                end else begin
                    s_d.ent[IW'(s_q.depth)] = addr;
                    s_d.depth               = s_q.depth + DW'(1);
                end
            end
        end else if (cmd.pop) begin
            if (s_q.depth == '0) begin
                s_d.unf = 1'b1;
            end else if (s_q.depth == DW'(1)) begin
                s_d.depth = '0;
                s_d.act   = 1'b0;
                s_d.done  = 1'b1;
            end else begin
                s_d.depth        = s_q.depth - DW'(1);
                s_d.ent[sec_idx] = sec_q + AW'(1);
            end
        end else if (cmd.adv) begin
            if (s_q.depth != '0) begin
                s_d.ent[top_idx] = top_q + AW'(1);
            end
        end

        nxt_idx    = IW'(s_d.depth - DW'(1));
        top_next   = (s_d.depth != '0) ? s_d.ent[nxt_idx] : '0;
        depth_next = s_d.depth;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign depth_q  = s_q.depth;
    assign active_q = s_q.act;
    assign ovf_q    = s_q.ovf;
    assign unf_q    = s_q.unf;
    assign done_q   = s_q.done;

    p_active_tracks_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.act == (s_q.depth != '0));

    p_call_pushes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.push && s_q.act && s_q.depth < DW'(DEPTH))
        |=> (top_q == $past(addr) && s_q.depth == $past(s_q.depth) + DW'(1)));

    p_ret_resumes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.pop && s_q.depth > DW'(1)) |=> (top_q == $past(sec_q) + AW'(1)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.push && s_q.act && s_q.depth == DW'(DEPTH))
        |=> (s_q.ovf && s_q.depth == DW'(DEPTH)));

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.pop && s_q.depth == '0) |=> (s_q.unf && s_q.depth == '0));

    p_done_on_last_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.pop && s_q.depth == DW'(1)) |=> (s_q.done && !s_q.act));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

endmodule

// File: rtl/ctx_out_reg.sv
module ctx_out_reg #(
    parameter int NUM_CTX = 4,
    parameter int AW      = 16,
    parameter int DW      = 5,
    parameter int CW      = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CW-1:0]                 sel_d,
    input  logic [NUM_CTX-1:0][AW-1:0]    top_next,
    input  logic [NUM_CTX-1:0][DW-1:0]    depth_next,
    output logic [CW-1:0]                 sel_q,
    output logic [AW-1:0]                 cur_addr,
    output logic                          cur_valid,
    output logic [DW-1:0]                 cur_depth
);

    typedef struct packed {
        logic [CW-1:0] sel;
        logic [AW-1:0] addr;
        logic          valid;
        logic [DW-1:0] depth;
    } out_st_t;

    out_st_t o_d, o_q;

    always_comb begin
        o_d.sel   = sel_d;
        o_d.addr  = top_next[sel_d];
        o_d.depth = depth_next[sel_d];
        o_d.valid = (depth_next[sel_d] != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign sel_q     = o_q.sel;
    assign cur_addr  = o_q.addr;
    assign cur_valid = o_q.valid;
    assign cur_depth = o_q.depth;

    p_empty_addr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !o_q.valid |-> (o_q.addr == '0));

endmodule

// File: rtl/ctx_hier_stack.sv
module ctx_hier_stack
    import ctx_hier_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int DEPTH   = 16,
    parameter int AW      = 16,
    localparam int CW     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int DW     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         op,
    input  logic [AW-1:0]      op_addr,
    input  logic [CW-1:0]      op_ctx,
    output logic [AW-1:0]      cur_addr,
    output logic               cur_valid,
    output logic [DW-1:0]      cur_depth,
    output logic [CW-1:0]      cur_ctx,
    output logic [NUM_CTX-1:0] active_mask,
    output logic [NUM_CTX-1:0] ovf_flags,
    output logic [NUM_CTX-1:0] unf_flags,
    output logic [NUM_CTX-1:0] done_pulse
);

    lane_cmd_t [NUM_CTX-1:0]       cmd;
    logic [CW-1:0]                 sel_d, sel_q;
    logic [NUM_CTX-1:0][AW-1:0]    top_next;
    logic [NUM_CTX-1:0][DW-1:0]    depth_next;
    logic [NUM_CTX-1:0][DW-1:0]    depth_q;

    ctx_op_decode #(.NUM_CTX(NUM_CTX), .CW(CW)) u_decode (
        .op     (op),
        .op_ctx (op_ctx),
        .sel_q  (sel_q),
        .cmd    (cmd),
        .sel_d  (sel_d)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_lane
        ctx_lane #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd        (cmd[c]),
            .addr       (op_addr),
            .depth_q    (depth_q[c]),
            .active_q   (active_mask[c]),
            .ovf_q      (ovf_flags[c]),
            .unf_q      (unf_flags[c]),
            .done_q     (done_pulse[c]),
            .top_next   (top_next[c]),
            .depth_next (depth_next[c])
        );
    end

    ctx_out_reg #(.NUM_CTX(NUM_CTX), .AW(AW), .DW(DW), .CW(CW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_d      (sel_d),
        .top_next   (top_next),
        .depth_next (depth_next),
        .sel_q      (sel_q),
        .cur_addr   (cur_addr),
        .cur_valid  (cur_valid),
        .cur_depth  (cur_depth)
    );

    assign cur_ctx = sel_q;

    p_switch_next_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SEL) |=> (cur_ctx == $past(op_ctx)));

    p_depth_matches_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_depth == depth_q[cur_ctx]);

    p_done_one_ctx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_pulse));

    p_nop_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd0 || op == 3'd7) |=> ($stable(cur_addr) && $stable(active_mask)
                                        && $stable(cur_ctx)));

endmodule

// File: tb/ctx_hier_stack_tb.sv
`timescale 1ns/1ps
module ctx_hier_stack_tb;

    localparam int NC = 4;
    localparam int DP = 16;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [AW-1:0] op_addr = '0;
    logic [1:0]    op_ctx = '0;
    logic [AW-1:0] cur_addr;
    logic          cur_valid;
    logic [4:0]    cur_depth;
    logic [1:0]    cur_ctx;
    logic [NC-1:0] active_mask, ovf_flags, unf_flags, done_pulse;

    always #2 clk = ~clk;

    ctx_hier_stack u_dut (
        .clk(clk), .rst_n(rst_n), .op(op), .op_addr(op_addr), .op_ctx(op_ctx),
        .cur_addr(cur_addr), .cur_valid(cur_valid), .cur_depth(cur_depth),
        .cur_ctx(cur_ctx), .active_mask(active_mask), .ovf_flags(ovf_flags),
        .unf_flags(unf_flags), .done_pulse(done_pulse)
    );

    // Behavioural reference model
    int unsigned stk [NC][$];
    bit          m_ovf [NC];
    bit          m_unf [NC];
    bit          m_done [NC];
    int          m_sel;
    int          checks = 0;
    int          fails  = 0;
    bit          finished = 0;

    task automatic model_apply(input int o, input int a, input int c);
        for (int i = 0; i < NC; i++) m_done[i] = 0;
        case (o)
            1: if (stk[m_sel].size() != 0) begin
                   if (stk[m_sel].size() == DP) m_ovf[m_sel] = 1;
                   else stk[m_sel].push_back(a);
               end
            2: begin
                   int n = stk[m_sel].size();
                   if (n == 0) m_unf[m_sel] = 1;
                   else if (n == 1) begin
                       void'(stk[m_sel].pop_back());
                       m_done[m_sel] = 1;
                   end else begin
                       void'(stk[m_sel].pop_back());
                       stk[m_sel][n-2] = (stk[m_sel][n-2] + 1) & 16'hFFFF;
                   end
               end
            3: begin
                   int n = stk[m_sel].size();
                   if (n != 0) stk[m_sel][n-1] = (stk[m_sel][n-1] + 1) & 16'hFFFF;
               end
            4: if (stk[c].size() == 0) begin
                   stk[c].push_back(a);
                   m_ovf[c] = 0;
                   m_unf[c] = 0;
               end
            5: stk[c].delete();
            6: m_sel = c;
            default: ;
        endcase
    endtask

    task automatic compare(input string tag);
        logic [AW-1:0] e_addr;
        logic [NC-1:0] e_act, e_ovf, e_unf, e_done;
        int n = stk[m_sel].size();
        e_addr = (n != 0) ? AW'(stk[m_sel][n-1]) : '0;
        for (int i = 0; i < NC; i++) begin
            e_act[i]  = (stk[i].size() != 0);
            e_ovf[i]  = m_ovf[i];
            e_unf[i]  = m_unf[i];
            e_done[i] = m_done[i];
        end
        checks++;
        if (cur_addr !== e_addr || cur_valid !== (n != 0) || cur_depth !== 5'(n) ||
            cur_ctx !== 2'(m_sel) || active_mask !== e_act || ovf_flags !== e_ovf ||
            unf_flags !== e_unf || done_pulse !== e_done) begin
            fails++;
            $display("FAIL %s: addr %h exp %h, depth %0d exp %0d, ctx %0d exp %0d, act %b exp %b, ovf %b exp %b, unf %b exp %b, done %b exp %b",
                     tag, cur_addr, e_addr, cur_depth, n, cur_ctx, m_sel, active_mask, e_act,
                     ovf_flags, e_ovf, unf_flags, e_unf, done_pulse, e_done);
        end
    endtask

    task automatic step(input int o, input int a, input int c, input string tag);
        op      = 3'(o);
        op_addr = AW'(a);
        op_ctx  = 2'(c);
        @(posedge clk);
        #1;
        model_apply(o, a, c);
        compare(tag);
    endtask

    function automatic string tag_of(input int o);
        case (o)
            1: return "R3";
            2: return "R4";
            3: return "R10";
            4: return "R2";
            5: return "R9";
            6: return "R7";
            default: return "R11";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung, expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_sel = 0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1");                      // reset state
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare("R1");

        step(4, 'h0100, 0, "R2");           // create ctx0
        step(4, 'h0999, 0, "R2");           // create on active ctx: ignored
        step(1, 'h0200, 0, "R3");           // call
        step(3, 0, 0, "R10");               // advance
        step(1, 'h0300, 0, "R3");           // nested call
        step(2, 0, 0, "R4");                // return -> 0x0202
        step(2, 0, 0, "R4");                // return -> 0x0101
        step(6, 0, 1, "R7");                // switch to empty ctx1
        step(1, 'h0555, 0, "R11");          // call on inactive: ignored
        step(3, 0, 0, "R10");               // advance on empty: ignored
        step(2, 0, 0, "R6");                // underflow
        step(0, 'h1234, 3, "R11");
        step(7, 'h4321, 2, "R11");
        step(4, 'h0050, 1, "R2");           // create clears flags
        for (int i = 0; i < 15; i++) step(1, 'h1000 + i, 0, "R3");
        step(1, 'h2000, 0, "R5");           // call on full: refused
        step(1, 'h2001, 0, "R5");
        for (int i = 0; i < 15; i++) step(2, 0, 0, "R4");
        step(6, 0, 0, "R7");                // back to ctx0, stack intact
        step(4, 'hFFFF, 2, "R2");
        step(6, 0, 2, "R7");
        step(3, 0, 0, "R10");               // wraps to 0
        step(2, 0, 0, "R8");                // last return: done pulse
        step(0, 0, 0, "R8");                // pulse gone
        step(5, 0, 0, "R9");                // retire ctx0, no pulse
        step(6, 0, 1, "R7");
        step(5, 0, 1, "R9");
        step(4, 'h0777, 1, "R2");
        step(6, 0, 0, "R7");
        step(4, 'h0123, 0, "R2");

        for (int i = 0; i < 600; i++) begin
            int o = $urandom_range(0, 7);
            if (i % 5 == 0) o = 1;
            step(o, $urandom_range(0, 16'hFFFF), $urandom_range(0, NC - 1), tag_of(o));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule